// File: doc/BRIEF.md
# Prescaled Modulo Timer Counter

This block is a 16-bit up-counter for general timing. Its count enable comes from one of two places. The first is a free-running divider on the bus clock, with ratios from 1 to 64 in powers of two. The second is an external clock pin. That pin is brought into the bus clock domain through a synchronizer, and the counter then steps once for each rising edge it sees. The count runs from zero up to a programmable modulo value, returns to zero on the next step and sets an overflow flag. The flag can be routed to an interrupt output.

Software reaches the block through simple read and write strobes on an 8-bit data path. A control register holds the clock-select code, a stop bit, a self-clearing counter-clear bit, the interrupt enable and the overflow flag. When the external pin is selected, the block drives a direction-override output, and the pad logic uses it to keep that pin an input. Reading the counter is coherent across its two bytes. Reading the high byte freezes a copy of the low byte, and the next low-byte read returns that copy.

Top module: `modtmr_top`

## Requirements
- R1: After reset the count is 0, the modulo value is 0xFFFF and the control register reads 0x20 (counter stopped, select code 000, interrupt disabled, flag clear). Register addresses are: 0 control, 1 count high byte, 2 count low byte, 3 modulo high byte, 4 modulo low byte. Writes to addresses 1 and 2 are ignored.
- R2: Control bits [2:0] hold the clock-select code. Codes 0 to 6 make the count advance once every 2^code bus cycles. The divider starts from zero at a clear, so the first step comes 2^code cycles after the clear.
- R3: Select code 7 makes the counter advance once for each rising edge of `ext_clk_pin`, after a two-flop synchronizer and an edge detector, and no longer on the bus divider. `pin_input_force` is 1 exactly while the code is 7.
- R4: While control bit 5 (stop) is 1, the count holds its value, the divider holds its value, and edges on the external pin are not counted.
- R5: Writing control bit 4 as 1 zeroes the count and the divider at that write's clock edge. The bit always reads back as 0.
- R6: A step taken while the count equals the modulo value sets the count to 0. Any other step adds exactly 1, so the count repeats with a period of modulo+1 steps.
- R7: A wrap to 0 sets the overflow flag (control bit 7) at the same edge. A wrap wins over a clear attempted in the same cycle.
- R8: The overflow flag clears only when control is written with bit 7 = 0 after a control read that saw the flag set. A write of 0 that was not preceded by such a read leaves the flag set.
- R9: `irq` is 1 exactly when the overflow flag and control bit 6 (interrupt enable) are both 1.
- R10: A read of the count high byte captures the low byte. The next read of the low byte returns the captured value, even if the counter has moved on since.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read strobe for the register at `addr` |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while `rd_en` is high |
| ext_clk_pin | input | 1 | External counter clock pin, asynchronous to `clk` |
| pin_input_force | output | 1 | Forces the external clock pad into input mode |
| irq | output | 1 | Overflow interrupt request |

## Verification
The assertions watch the following on every cycle:
- the count holds while the counter is stopped;
- the count goes to zero after a clear and after a step taken at the modulo value;
- any other change of the count is a single increment;
- the flag is set after each wrap;
- with the external source selected, the count changes only when a synchronized rising edge is seen.

Only the bench's scenarios can show the exact divide ratio for each select code, and the number of pin pulses that get counted. The same holds for the read-then-write protocol that clears the flag and for the two-byte read coherence, because each of these depends on sequences of register accesses.

// File: rtl/modtmr_pkg.sv
package modtmr_pkg;

  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] REG_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] REG_CNT_HI = 3'd1;
  localparam logic [ADDR_W-1:0] REG_CNT_LO = 3'd2;
  localparam logic [ADDR_W-1:0] REG_MOD_HI = 3'd3;
  localparam logic [ADDR_W-1:0] REG_MOD_LO = 3'd4;

  localparam int BIT_FLAG = 7;
  localparam int BIT_IE   = 6;
  localparam int BIT_HALT = 5;
  localparam int BIT_CLR  = 4;

endpackage

// File: rtl/modtmr_prescale.sv
module modtmr_prescale #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic [SEL_W-1:0] code,
  output logic             tick
);
  localparam int N_CODES = 1 << SEL_W;
  localparam int N_DIV   = N_CODES - 1;   // codes that select a divide ratio
  localparam int DIV_W   = N_DIV - 1;     // divider width for the largest ratio

  logic [DIV_W-1:0]   div_q, div_d;
  logic [N_CODES-1:0] tap;

  always_comb begin
    div_d = div_q;
    if (clr)      div_d = '0;
    else if (run) div_d = div_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  assign tap[0]       = 1'b1;
  assign tap[N_DIV]   = 1'b0;   // the all-ones code takes no tap
  generate
    for (genvar k = 1; k < N_DIV; k++) begin : g_tap
      assign tap[k] = &div_q[k-1:0];
    end
  endgenerate

  assign tick = tap[code];

endmodule

// File: rtl/modtmr_edge_sync.sv
module modtmr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise
);
  logic [STAGES:0] sh_q, sh_d;

  always_comb sh_d = {sh_q[STAGES-1:0], pin};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];

endmodule

// File: rtl/modtmr_count.sv
module modtmr_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic [CNT_W-1:0] modulo,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign wrap = step & ~clr & (cnt_q == modulo);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (wrap) cnt_d = '0;
    else if (step) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;

endmodule

// File: rtl/modtmr_top.sv
module modtmr_top
  import modtmr_pkg::*;
#(
  parameter int CNT_W       = 16,   // two data bytes
  parameter int SEL_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              ext_clk_pin,
  output logic              pin_input_force,
  output logic              irq
);
  localparam logic [SEL_W-1:0] EXT_CODE = '1;

  logic              ie_q, ie_d;
  logic              halt_q, halt_d;
  logic [SEL_W-1:0]  code_q, code_d;
  logic              flag_q, flag_d;
  logic              armed_q, armed_d;
  logic [CNT_W-1:0]  mod_q, mod_d;
  logic [DATA_W-1:0] lo_cap_q, lo_cap_d;
  logic              cap_vld_q, cap_vld_d;

  logic wr_ctrl, rd_ctrl, clr_pulse, flag_clr_try;
  logic ext_sel, ext_rise, pre_tick, cnt_step, wrap;
  logic [CNT_W-1:0]  count;
  logic [DATA_W-1:0] rd_mux;
  logic unused_bits;

  assign unused_bits = wdata[3];

  assign wr_ctrl      = wr_en & (addr == REG_CTRL);
  assign rd_ctrl      = rd_en & (addr == REG_CTRL);
  assign clr_pulse    = wr_ctrl & wdata[BIT_CLR];
  assign flag_clr_try = wr_ctrl & ~wdata[BIT_FLAG];
  assign ext_sel      = (code_q == EXT_CODE);

  modtmr_prescale #(.SEL_W(SEL_W)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (~halt_q & ~ext_sel),
    .clr  (clr_pulse),
    .code (code_q),
    .tick (pre_tick)
  );

  modtmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  (ext_clk_pin),
    .rise (ext_rise)
  );

  assign cnt_step = ~halt_q & (ext_sel ? ext_rise : pre_tick);

  modtmr_count #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr_pulse),
    .step  (cnt_step),
    .modulo(mod_q),
    .count (count),
    .wrap  (wrap)
  );

  // control and modulo next state
  always_comb begin
    ie_d   = ie_q;
    halt_d = halt_q;
    code_d = code_q;
    mod_d  = mod_q;
    if (wr_ctrl) begin
      ie_d   = wdata[BIT_IE];
      halt_d = wdata[BIT_HALT];
      code_d = wdata[SEL_W-1:0];
    end
    if (wr_en && addr == REG_MOD_HI) mod_d[CNT_W-1 -: DATA_W] = wdata;
    if (wr_en && addr == REG_MOD_LO) mod_d[DATA_W-1:0]        = wdata;
  end

  // overflow flag with read-then-write clear; a wrap wins
  always_comb begin
    flag_d  = flag_q;
    armed_d = armed_q;
    if (rd_ctrl && flag_q) armed_d = 1'b1;
    if (flag_clr_try) begin
      if (armed_q) flag_d = 1'b0;
      armed_d = 1'b0;
    end
    if (wrap) flag_d = 1'b1;
  end

  // low-byte capture for coherent two-byte reads
  always_comb begin
    lo_cap_d  = lo_cap_q;
    cap_vld_d = cap_vld_q;
    if (rd_en && addr == REG_CNT_HI) begin
      lo_cap_d  = count[DATA_W-1:0];
      cap_vld_d = 1'b1;
    end else if (rd_en && addr == REG_CNT_LO) begin
      cap_vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q      <= 1'b0;
      halt_q    <= 1'b1;
      code_q    <= '0;
      flag_q    <= 1'b0;
      armed_q   <= 1'b0;
      mod_q     <= '1;
      lo_cap_q  <= '0;
      cap_vld_q <= 1'b0;
    end else begin
      ie_q      <= ie_d;
      halt_q    <= halt_d;
      code_q    <= code_d;
      flag_q    <= flag_d;
      armed_q   <= armed_d;
      mod_q     <= mod_d;
      lo_cap_q  <= lo_cap_d;
      cap_vld_q <= cap_vld_d;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      REG_CTRL: begin
        rd_mux[BIT_FLAG]    = flag_q;
        rd_mux[BIT_IE]      = ie_q;
        rd_mux[BIT_HALT]    = halt_q;
        rd_mux[SEL_W-1:0]   = code_q;
      end
      REG_CNT_HI: rd_mux = count[CNT_W-1 -: DATA_W];
      REG_CNT_LO: rd_mux = cap_vld_q ? lo_cap_q : count[DATA_W-1:0];
      REG_MOD_HI: rd_mux = mod_q[CNT_W-1 -: DATA_W];
      REG_MOD_LO: rd_mux = mod_q[DATA_W-1:0];
      default:    rd_mux = '0;
    endcase
  end

  assign rdata           = rd_en ? rd_mux : '0;
  assign pin_input_force = ext_sel;
  assign irq             = flag_q & ie_q;

endmodule

// File: rtl/modtmr_checker.sv
module modtmr_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             halt,
  input logic             clr,
  input logic             step,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] modulo,
  input logic             wrap,
  input logic             flag,
  input logic             ext_sel,
  input logic             ext_rise
);

  p_hold_when_halted_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !clr) |=> $stable(count));

  p_clear_zeroes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));

  p_wrap_to_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr && count == modulo) |=> (count == '0));

  p_single_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && count != modulo) |=>
      (count == $past(count) || count == $past(count) + CNT_W'(1)));

  p_flag_after_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> flag);

  p_ext_edges_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_sel && !ext_rise && !clr) |=> $stable(count));

endmodule

bind modtmr_top modtmr_checker #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .halt    (halt_q),
  .clr     (clr_pulse),
  .step    (cnt_step),
  .count   (count),
  .modulo  (mod_q),
  .wrap    (wrap),
  .flag    (flag_q),
  .ext_sel (ext_sel),
  .ext_rise(ext_rise)
);

// File: tb/modtmr_top_tb.sv
`timescale 1ns/1ps
module modtmr_top_tb;

  logic       clk;
  logic       rst_n;
  logic       rd_en, wr_en;
  logic [2:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       ext_clk_pin;
  logic       pin_input_force;
  logic       irq;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  modtmr_top u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .rd_en          (rd_en),
    .wr_en          (wr_en),
    .addr           (addr),
    .wdata          (wdata),
    .rdata          (rdata),
    .ext_clk_pin    (ext_clk_pin),
    .pin_input_force(pin_input_force),
    .irq            (irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // ctrl bits: 7 flag, 6 ie, 5 stop, 4 clear, 2:0 select code
  localparam logic [7:0] C_HALT = 8'h20;
  localparam logic [7:0] C_CLR  = 8'h10;
  localparam logic [7:0] C_IE   = 8'h40;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    addr = a; rd_en = 1'b1;
    #1 v = rdata;
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic rd_count(output int v);
    logic [7:0] h, l;
    rd(3'd1, h);
    rd(3'd2, l);
    v = {h, l};
  endtask

  task automatic set_mod(input int m);
    wr(3'd3, m[15:8]);
    wr(3'd4, m[7:0]);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      ext_clk_pin = 1'b1; idle(2);
      ext_clk_pin = 1'b0; idle(2);
    end
  endtask

  initial begin
    logic [7:0] v;
    int cnt, expc, steps;
    rst_n = 1'b0; rd_en = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    ext_clk_pin = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    rd(3'd0, v);  check("R1 ctrl reset", v, 8'h20);
    rd_count(cnt); check("R1 count reset", cnt, 0);
    rd(3'd3, v);  check("R1 mod hi reset", v, 8'hFF);
    rd(3'd4, v);  check("R1 mod lo reset", v, 8'hFF);
    check("R1 irq reset", irq, 0);
    check("R3 force low at reset", pin_input_force, 0);
    wr(3'd1, 8'h55); wr(3'd2, 8'hAA);
    rd_count(cnt); check("R1 count write ignored", cnt, 0);

    // R2 R6 R7 sweep over select codes, modulo values and run lengths
    for (int code = 0; code < 7; code++) begin
      for (int mi = 0; mi < 2; mi++) begin
        for (int ni = 0; ni < 2; ni++) begin
          int d, m, n;
          d = 1 << code;
          m = (mi == 0) ? 4 : 16'hFFFF;
          n = 7 * d - 1 + ni;
          set_mod(m);
          wr(3'd0, C_CLR | 8'(code));
          idle(n - 1);
          wr(3'd0, C_HALT | 8'(code));
          steps = n / d;
          expc  = steps % (m + 1);
          rd_count(cnt);
          check($sformatf("R2 R6 count code=%0d mod=%0d n=%0d", code, m, n), cnt, expc);
          rd(3'd0, v);
          check($sformatf("R7 flag code=%0d mod=%0d", code, m), v[7], (steps > m) ? 1 : 0);
          check("R3 force low for divider code", pin_input_force, 0);
        end
      end
    end
    wr(3'd0, C_HALT);  // clears the flag armed by the last read, if set

    // R9 R8 interrupt and flag clear protocol
    set_mod(3);
    wr(3'd0, C_IE | C_CLR);
    idle(9);
    wr(3'd0, C_IE | C_HALT);     // 10 steps with modulo 3 -> count 2, wrapped
    rd_count(cnt); check("R6 count after wraps", cnt, 2);
    check("R9 irq with enable", irq, 1);
    wr(3'd0, C_IE | C_HALT);     // bit7=0 without prior read
    rd(3'd0, v); check("R8 flag kept without read", v[7], 1);
    wr(3'd0, C_IE | C_HALT);     // after the read: clears
    rd(3'd0, v); check("R8 flag cleared after read", v[7], 0);
    check("R9 irq drops with flag", irq, 0);
    wr(3'd0, C_CLR);             // ie=0, running
    idle(9);
    wr(3'd0, C_HALT);
    rd(3'd0, v); check("R7 flag set again", v[7], 1);
    check("R9 irq gated by enable", irq, 0);

    // R5 clear while stopped, readback 0
    rd_count(cnt); check("R5 precondition nonzero", (cnt != 0) ? 1 : 0, 1);
    wr(3'd0, C_HALT | C_CLR);
    rd_count(cnt); check("R5 clear while stopped", cnt, 0);
    rd(3'd0, v); check("R5 clear bit reads 0", v[4], 0);

    // R4 stop holds
    set_mod(16'hFFFF);
    wr(3'd0, C_CLR);
    idle(19);
    wr(3'd0, C_HALT);
    idle(50);
    rd_count(cnt); check("R4 hold while stopped", cnt, 20);

    // R3 external clock source
    wr(3'd0, C_CLR | 8'h07);
    check("R3 force high for code 7", pin_input_force, 1);
    pulses(9);
    idle(6);
    wr(3'd0, C_HALT | 8'h07);
    rd_count(cnt); check("R3 external edges counted", cnt, 9);
    pulses(5);
    idle(6);
    rd_count(cnt); check("R4 external edges ignored while stopped", cnt, 9);
    wr(3'd0, C_HALT);
    check("R3 force released", pin_input_force, 0);

    // R10 coherent two-byte read on a running counter
    wr(3'd0, C_CLR);
    idle(16'h1FF);
    rd(3'd1, v); check("R10 high byte", v, 8'h01);
    idle(5);
    rd(3'd2, v); check("R10 captured low byte", v, 8'hFF);
    wr(3'd0, C_HALT);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule